// File: doc/BRIEF.md
# Reconfigurable Task Schedule Sequencer

This block plays back precomputed static schedules for hardware task graphs. Graph requests enter a request queue. Each request carries a graph number and the cycle at which that graph's schedule changes from its left part to its right part. The sequencer takes one request at a time and steps through that graph's instruction list. The list is held in an external schedule memory. For each instruction it issues a reconfigure or execute command, then waits until the instruction's finishing cycle has been reached. A reconfigure instruction also waits for the reconfiguration engine to report that it is done.

Schedules were precomputed for every pair of neighbouring graphs, so the fetch address has to pick the right variant. The left part of a schedule is looked up by the graph that ran before. The right part is looked up by the graph waiting next in the queue. An instruction marked early-fetched belongs to that next graph, and its command is tagged with the next graph's number. A reserved null graph number (all ones) selects the unmodified default schedule. It is used after reset, after a graph that had no successor waiting, and whenever the queue is empty during a right-part fetch.

The controller is a five-state machine:
- **IDLE** waits for a request. The transition IDLE→FETCH takes the queue head.
- **FETCH** drives the memory address.
- **DECODE** receives the word. DECODE→RUN follows for an instruction, and DECODE→END follows for the end marker.
- **RUN** counts cycles. RUN→FETCH follows on completion.
- **END** updates the previous-graph register. END→IDLE follows.

Top module: `sched_seq_top`

## Requirements
- R1: After reset, cmd_valid, sched_rd and q_full are 0. While the queue is empty, no schedule fetch is made.
- R2: A request is stored when req_push is high and q_full is low. q_full is high while Q_DEPTH requests are held. A push while q_full is high is ignored, and that graph is never run.
- R3: In IDLE with a non-empty queue, the head request is removed. Its graph number becomes the current graph and its boundary becomes the current boundary. The cycle counter and the instruction counter both start at 0.
- R4: sched_addr is, from MSB to LSB: side bit, neighbour graph (GW bits), current graph (GW bits), instruction counter (ICW bits). sched_rdata is returned one clock after the cycle in which sched_rd is high.
- R5: The side bit is 0 while the cycle counter is below the current boundary, and 1 otherwise.
- R6: The neighbour field is the previous-graph register when the side bit is 0. When the side bit is 1, it is the queue-head graph, or the null value 15 if the queue is empty.
- R7: The instruction word is, from MSB to LSB: task (TW bits), reconfigure flag (1 = reconfigure, 0 = execute), start cycle (CW bits), duration (CW bits), early-fetched flag. A word of all ones ends the schedule.
- R8: Each instruction produces a one-cycle cmd_valid strobe in the first RUN cycle. The strobe carries cmd_task and cmd_reconf. cmd_graph is the current graph, or the next graph (queue head, else null) when the early-fetched flag is 1.
- R9: An execute instruction completes once the cycle counter is at or beyond start+duration. The counter rises by 1 in every RUN cycle in which the instruction is incomplete. So the time between consecutive strobes is (start+duration−counter)+3 cycles, and it is 3 cycles when that difference is negative.
- R10: A reconfigure instruction completes only when the completion condition of R9 holds and cfg_done is high. No fetch is made while it waits.
- R11: At the end marker, the previous-graph register takes the current graph if another request is queued, and otherwise takes null (15). Both counters return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_push | input | 1 | Enqueue a graph request |
| req_graph | input | GW | Requested graph number |
| req_bound | input | CW | Left/right boundary cycle of that graph |
| q_full | output | 1 | Request queue full |
| sched_rd | output | 1 | Schedule memory read strobe |
| sched_addr | output | 1+2*GW+ICW | Schedule memory address |
| sched_rdata | input | TW+2*CW+2 | Schedule word, one cycle after the read |
| cfg_done | input | 1 | Reconfiguration finished |
| cmd_valid | output | 1 | Command strobe |
| cmd_reconf | output | 1 | 1 = reconfigure, 0 = execute |
| cmd_task | output | TW | Task number of the command |
| cmd_graph | output | GW | Graph the command belongs to |

## Verification
The following rules are checked on every cycle:
- cmd_valid is a single-cycle strobe that never coincides with a fetch.
- The side bit of every fetch address agrees with the comparison of the counter against the boundary.
- The counter steps by exactly one while an instruction is incomplete.
- No instruction leaves RUN while its reconfiguration is pending.
- The previous-graph register becomes null after a graph ends with an empty queue.

Other behaviour can only be shown by the directed scenarios: the exact address sequences across a pair of graphs, retagging of an early-fetched command, strobe spacing that follows from the finishing cycles, and the dropping of a request pushed into a full queue.

// File: rtl/sched_seq_pkg.sv
package sched_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_RUN,
        ST_END
    } seq_state_e;

    localparam int DEF_GW      = 4;
    localparam int DEF_TW      = 4;
    localparam int DEF_ICW     = 5;
    localparam int DEF_CW      = 20;
    localparam int DEF_Q_DEPTH = 256;

endpackage

// File: rtl/seq_req_fifo.sv
module seq_req_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0]   LAST = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    logic [W-1:0]    store [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] count;
    logic            wr_en, rd_en;

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
    assign wr_en = push && !full;
    assign rd_en = pop && !empty;
    assign dout  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen #(
    parameter int GW  = 4,
    parameter int ICW = 5,
    parameter int CW  = 20
) (
    input  logic [CW-1:0]         cnt,
    input  logic [CW-1:0]         bound,
    input  logic [GW-1:0]         prev_graph,
    input  logic [GW-1:0]         head_graph,
    input  logic                  head_valid,
    input  logic [GW-1:0]         cur_graph,
    input  logic [ICW-1:0]        icnt,
    output logic [2*GW+ICW:0]     addr,
    output logic [GW-1:0]         next_graph
);
    localparam logic [GW-1:0] NULL_G = '1;

    logic            side;
    logic [GW-1:0]   neigh;

    always_comb begin
        side       = (cnt >= bound);
        next_graph = head_valid ? head_graph : NULL_G;
        neigh      = side ? next_graph : prev_graph;
        addr       = {side, neigh, cur_graph, icnt};
    end
endmodule

// File: rtl/seq_step_check.sv
module seq_step_check #(
    parameter int CW = 20
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] dur,
    input  logic          reconf,
    input  logic          cfg_done,
    output logic          done
);
    logic [CW:0] finish;
    logic        time_ok;

    always_comb begin
        finish  = {1'b0, start} + {1'b0, dur};
        time_ok = ({1'b0, cnt} >= finish);
        done    = time_ok && (!reconf || cfg_done);
    end
endmodule

// File: rtl/sched_seq_top.sv
module sched_seq_top
    import sched_seq_pkg::*;
#(
    parameter int GW      = DEF_GW,
    parameter int TW      = DEF_TW,
    parameter int ICW     = DEF_ICW,
    parameter int CW      = DEF_CW,
    parameter int Q_DEPTH = DEF_Q_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_push,
    input  logic [GW-1:0]         req_graph,
    input  logic [CW-1:0]         req_bound,
    output logic                  q_full,
    output logic                  sched_rd,
    output logic [2*GW+ICW:0]     sched_addr,
    input  logic [TW+2*CW+1:0]    sched_rdata,
    input  logic                  cfg_done,
    output logic                  cmd_valid,
    output logic                  cmd_reconf,
    output logic [TW-1:0]         cmd_task,
    output logic [GW-1:0]         cmd_graph
);
    localparam int IW  = TW + 2*CW + 2;
    localparam int QW  = GW + CW;
    localparam int RC_BIT = IW - TW - 1;
    localparam logic [GW-1:0] NULL_G = '1;

    seq_state_e state_q, state_d;

    logic [GW-1:0]  cur_q, prev_q, head_graph, next_graph;
    logic [CW-1:0]  bnd_q, cnt_q, head_bound;
    logic [ICW-1:0] icnt_q;
    logic [IW-1:0]  instr_q;
    logic [QW-1:0]  q_dout;
    logic           q_empty, q_pop, run_done, word_end;

    logic [TW-1:0]  ins_task;
    logic           ins_reconf, ins_ef;
    logic [CW-1:0]  ins_start, ins_dur;

    assign {head_graph, head_bound} = q_dout;
    assign q_pop    = (state_q == ST_IDLE) && !q_empty;
    assign word_end = &sched_rdata;

    assign ins_task   = instr_q[IW-1 -: TW];
    assign ins_reconf = instr_q[RC_BIT];
    assign ins_start  = instr_q[2*CW -: CW];
    assign ins_dur    = instr_q[CW -: CW];
    assign ins_ef     = instr_q[0];

    seq_req_fifo #(.W(QW), .DEPTH(Q_DEPTH)) i_req_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_push),
        .pop   (q_pop),
        .din   ({req_graph, req_bound}),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    seq_addr_gen #(.GW(GW), .ICW(ICW), .CW(CW)) i_addr_gen (
        .cnt        (cnt_q),
        .bound      (bnd_q),
        .prev_graph (prev_q),
        .head_graph (head_graph),
        .head_valid (!q_empty),
        .cur_graph  (cur_q),
        .icnt       (icnt_q),
        .addr       (sched_addr),
        .next_graph (next_graph)
    );

    seq_step_check #(.CW(CW)) i_step_check (
        .cnt      (cnt_q),
        .start    (ins_start),
        .dur      (ins_dur),
        .reconf   (ins_reconf),
        .cfg_done (cfg_done),
        .done     (run_done)
    );

    assign sched_rd = (state_q == ST_FETCH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!q_empty) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = word_end ? ST_END : ST_RUN;
            ST_RUN:    if (run_done) state_d = ST_FETCH;
            ST_END:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= NULL_G;
            prev_q  <= NULL_G;
            bnd_q   <= '0;
            cnt_q   <= '0;
            icnt_q  <= '0;
            instr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!q_empty) begin
                        cur_q  <= head_graph;
                        bnd_q  <= head_bound;
                        cnt_q  <= '0;
                        icnt_q <= '0;
                    end
                end
                ST_FETCH: ;
                ST_DECODE: instr_q <= sched_rdata;
                ST_RUN: begin
                    if (run_done) icnt_q <= icnt_q + 1'b1;
                    else          cnt_q  <= cnt_q + 1'b1;
                end
                ST_END: begin
                    prev_q <= q_empty ? NULL_G : cur_q;
                    cnt_q  <= '0;
                    icnt_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_reconf <= 1'b0;
            cmd_task   <= '0;
            cmd_graph  <= '0;
        end else begin
            cmd_valid <= (state_q == ST_DECODE) && !word_end;
            if ((state_q == ST_DECODE) && !word_end) begin
                cmd_task   <= sched_rdata[IW-1 -: TW];
                cmd_reconf <= sched_rdata[RC_BIT];
                cmd_graph  <= sched_rdata[0] ? next_graph : cur_q;
            end
        end
    end

    logic unused_ok;
    assign unused_ok = ins_ef ^ (|ins_task);
endmodule

// File: rtl/sched_seq_checker.sv
module sched_seq_checker
    import sched_seq_pkg::*;
#(
    parameter int GW  = 4,
    parameter int ICW = 5,
    parameter int CW  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              sched_rd,
    input  logic [2*GW+ICW:0] sched_addr,
    input  seq_state_e        state,
    input  logic [CW-1:0]     cnt,
    input  logic [CW-1:0]     bound,
    input  logic              run_done,
    input  logic              ins_reconf,
    input  logic              cfg_done,
    input  logic [GW-1:0]     prev_graph,
    input  logic              q_empty
);
    localparam int AW = 2*GW + ICW + 1;

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r8_no_fetch_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !sched_rd);

    a_r5_left_side: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_rd && (cnt < bound)) |-> !sched_addr[AW-1]);

    a_r5_right_side: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_rd && (cnt >= bound)) |-> sched_addr[AW-1]);

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !run_done) |=> (cnt == $past(cnt) + 1'b1));

    a_r10_reconf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && ins_reconf && !cfg_done) |=> (state == ST_RUN && !sched_rd));

    a_r11_null_prev: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END && q_empty) |=> (&prev_graph));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sched_rd);
endmodule

bind sched_seq_top sched_seq_checker #(.GW(GW), .ICW(ICW), .CW(CW)) i_sched_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .sched_rd   (sched_rd),
    .sched_addr (sched_addr),
    .state      (state_q),
    .cnt        (cnt_q),
    .bound      (bnd_q),
    .run_done   (run_done),
    .ins_reconf (ins_reconf),
    .cfg_done   (cfg_done),
    .prev_graph (prev_q),
    .q_empty    (q_empty)
);

// File: tb/test_sched_seq_top.sv
`timescale 1ns/1ps
module test_sched_seq_top;
    localparam int GW = 4, TW = 4, ICW = 5, CW = 20, QD = 4;
    localparam int IW = TW + 2*CW + 2;
    localparam int AW = 2*GW + ICW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_push = 1'b0;
    logic [GW-1:0] req_graph = '0;
    logic [CW-1:0] req_bound = '0;
    logic q_full, sched_rd, cmd_valid, cmd_reconf;
    logic [AW-1:0] sched_addr;
    logic [IW-1:0] sched_rdata = '1;
    logic cfg_done = 1'b1;
    logic [TW-1:0] cmd_task;
    logic [GW-1:0] cmd_graph;

    always #2.5 clk = ~clk;

    sched_seq_top #(.GW(GW), .TW(TW), .ICW(ICW), .CW(CW), .Q_DEPTH(QD)) i_sched_seq_top (
        .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_graph(req_graph),
        .req_bound(req_bound), .q_full(q_full), .sched_rd(sched_rd),
        .sched_addr(sched_addr), .sched_rdata(sched_rdata), .cfg_done(cfg_done),
        .cmd_valid(cmd_valid), .cmd_reconf(cmd_reconf), .cmd_task(cmd_task),
        .cmd_graph(cmd_graph)
    );

    logic [IW-1:0] mem [int];
    always @(posedge clk)
        sched_rdata <= mem.exists(int'(sched_addr)) ? mem[int'(sched_addr)] : '1;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int f_addr[$];
    int f_cyc[$];
    int c_task[$];
    int c_rc[$];
    int c_graph[$];
    int c_cyc[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && sched_rd) begin
            f_addr.push_back(int'(sched_addr));
            f_cyc.push_back(cyc);
        end
        if (rst_n && cmd_valid) begin
            c_task.push_back(int'(cmd_task));
            c_rc.push_back(int'(cmd_reconf));
            c_graph.push_back(int'(cmd_graph));
            c_cyc.push_back(cyc);
        end
    end

    function automatic logic [IW-1:0] mk(int t, int rc, int st, int du, int ef);
        return {TW'(t), 1'(rc), CW'(st), CW'(du), 1'(ef)};
    endfunction

    function automatic int ad(int side, int nb, int cur, int ic);
        return int'({1'(side), GW'(nb), GW'(cur), ICW'(ic)});
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        f_addr.delete(); f_cyc.delete();
        c_task.delete(); c_rc.delete(); c_graph.delete(); c_cyc.delete();
    endtask

    task automatic push_req(int g, int b);
        @(negedge clk);
        req_push = 1'b1; req_graph = GW'(g); req_bound = CW'(b);
        @(negedge clk);
        req_push = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R1 cmd_valid after reset", cmd_valid, 0);
        chk(sched_rd == 1'b0, "R1 sched_rd after reset", sched_rd, 0);
        chk(q_full == 1'b0, "R1 q_full after reset", q_full, 0);
        clear_logs();
        wait_cyc(20);
        chk(f_addr.size() == 0, "R1 no fetch on empty queue", f_addr.size(), 0);
    endtask

    task automatic t_single();
        clear_logs();
        mem[ad(0, 15, 2, 0)] = mk(3, 0, 0, 4, 0);
        push_req(2, 100);
        wait_cyc(30);
        chk(f_addr.size() == 2, "R4 fetch count single", f_addr.size(), 2);
        if (f_addr.size() == 2) begin
            chk(f_addr[0] == ad(0, 15, 2, 0), "R3 R6 first address", f_addr[0], ad(0, 15, 2, 0));
            chk(f_addr[1] == ad(0, 15, 2, 1), "R4 second address", f_addr[1], ad(0, 15, 2, 1));
        end
        chk(c_task.size() == 1, "R8 command count single", c_task.size(), 1);
        if (c_task.size() == 1 && f_cyc.size() == 2) begin
            chk(c_task[0] == 3 && c_rc[0] == 0 && c_graph[0] == 2, "R8 command fields",
                c_task[0] * 256 + c_rc[0] * 16 + c_graph[0], 3 * 256 + 2);
            chk(f_cyc[1] - c_cyc[0] == 5, "R9 execute finish timing", f_cyc[1] - c_cyc[0], 5);
        end
    endtask

    task automatic t_pair();
        int exp_a[6];
        clear_logs();
        mem[ad(0, 15, 1, 0)] = mk(1, 0, 0, 3, 0);
        mem[ad(0, 15, 1, 1)] = mk(2, 0, 3, 5, 0);
        mem[ad(1, 6, 1, 2)]  = mk(5, 1, 8, 2, 1);
        mem[ad(0, 1, 6, 0)]  = mk(7, 0, 0, 1, 0);
        push_req(1, 5);
        push_req(6, 50);
        wait_cyc(60);
        exp_a = '{ad(0, 15, 1, 0), ad(0, 15, 1, 1), ad(1, 6, 1, 2),
                  ad(1, 6, 1, 3), ad(0, 1, 6, 0), ad(0, 1, 6, 1)};
        chk(f_addr.size() == 6, "R4 fetch count pair", f_addr.size(), 6);
        if (f_addr.size() == 6) begin
            for (int i = 0; i < 6; i++)
                chk(f_addr[i] == exp_a[i], "R5 R6 R11 pair address", f_addr[i], exp_a[i]);
        end
        chk(c_task.size() == 4, "R8 command count pair", c_task.size(), 4);
        if (c_task.size() == 4) begin
            chk(c_graph[1] == 1 && c_task[1] == 2, "R8 left command tag", c_graph[1], 1);
            chk(c_graph[2] == 6 && c_rc[2] == 1 && c_task[2] == 5,
                "R8 R7 early-fetched retag", c_graph[2], 6);
            chk(c_graph[3] == 6 && c_task[3] == 7, "R3 next graph command", c_graph[3], 6);
            chk(c_cyc[1] - c_cyc[0] == 6, "R9 gap from zero", c_cyc[1] - c_cyc[0], 6);
            chk(c_cyc[2] - c_cyc[1] == 8, "R9 gap from counter 3", c_cyc[2] - c_cyc[1], 8);
        end
        clear_logs();
        push_req(3, 100);
        wait_cyc(10);
        chk(f_addr.size() == 1, "R11 fetch count after empty end", f_addr.size(), 1);
        if (f_addr.size() == 1)
            chk(f_addr[0] == ad(0, 15, 3, 0), "R11 null previous graph", f_addr[0], ad(0, 15, 3, 0));
    endtask

    task automatic t_stall_full();
        int n9 = 0;
        clear_logs();
        cfg_done = 1'b0;
        mem[ad(0, 15, 4, 0)] = mk(9, 1, 0, 2, 0);
        push_req(4, 10);
        wait_cyc(25);
        chk(f_addr.size() == 1, "R10 no fetch while waiting", f_addr.size(), 1);
        chk(c_task.size() == 1 && c_rc[0] == 1 && c_task[0] == 9, "R8 reconfigure command",
            c_task.size(), 1);
        for (int i = 0; i < QD; i++) push_req(0, 100);
        chk(q_full == 1'b1, "R2 full flag", q_full, 1);
        push_req(9, 100);
        chk(q_full == 1'b1, "R2 still full", q_full, 1);
        chk(f_addr.size() == 1, "R10 still waiting", f_addr.size(), 1);
        @(negedge clk);
        cfg_done = 1'b1;
        wait_cyc(60);
        chk(f_addr.size() == 6, "R2 fetch count drain", f_addr.size(), 6);
        if (f_addr.size() == 6) begin
            chk(f_addr[1] == ad(1, 0, 4, 1), "R10 R6 right fetch after release", f_addr[1], ad(1, 0, 4, 1));
            chk(f_addr[2] == ad(0, 4, 0, 0), "R11 previous graph kept", f_addr[2], ad(0, 4, 0, 0));
            chk(f_addr[5] == ad(0, 0, 0, 0), "R11 repeated graph", f_addr[5], ad(0, 0, 0, 0));
        end
        foreach (f_addr[i]) if (((f_addr[i] >> ICW) & 15) == 9) n9++;
        chk(n9 == 0, "R2 dropped request never runs", n9, 0);
        chk(q_full == 1'b0, "R2 full clears", q_full, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_pair();
        t_stall_full();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule